// File: doc/BRIEF.md
# Sixteen-Frame Bit Time Interleaver Controller

This block drives an external byte-wide SRAM that acts as a sixteen-frame time interleaving store. Each coded frame arrives as a stream of bytes after a start pulse. The block writes those bytes in order into the frame's own region of the SRAM. It then builds the interleaved frame one bit at a time. For each output bit position it picks an earlier frame, reads the byte that holds the same bit position in that frame, takes out that bit, and packs the bits into output bytes.

The SRAM has room for sixteen frame regions, each `FRAME_BYTES` bytes long. The region used by a frame is its slot number times `FRAME_BYTES`, and the slot number steps modulo 16 from one frame to the next. How far back a bit reaches depends on its position modulo 16. Until enough earlier frames have been stored, a bit whose source frame does not exist yet is output as zero.

Top module: `tint_ctrl`

## Requirements
- R1: After reset `out_valid` and `sram_we` are low, and the first frame uses slot 0 with no earlier frames counted.
- R2: A `frame_start` pulse while idle opens a write phase. Byte k of the frame, accepted with `in_valid`, is written to SRAM address slot*FRAME_BYTES + k, with `sram_we` high for one cycle. The slot is the frame number modulo 16.
- R3: Input bytes offered while the block is idle or in its read phase cause no SRAM write and have no effect on the output.
- R4: A `frame_start` pulse during a write or read phase is ignored: the byte count and the slot continue without change.
- R5: Once FRAME_BYTES bytes have been accepted, the block emits exactly FRAME_BYTES output bytes for that frame, each as a one-cycle `out_valid` pulse.
- R6: Frame bit i is bit 7-(i mod 8) of byte i/8, so bits are taken MSB first. Output bit i of frame r equals bit i of input frame r - d(i mod 16), where d for residues 0..15 is 0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15.
- R7: Any output bit whose source frame r - d is below zero is 0, whatever the SRAM holds at that address.
- R8: The slot pointer wraps from 15 to 0, and frames after the wrap still read their sources correctly.
- R9: Output bytes are spaced at least 8 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that opens a new frame when idle |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Coded input byte |
| sram_addr | output | ADDR_W | SRAM byte address (registered) |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write enable |
| sram_rdata | input | 8 | SRAM read data, valid one cycle after the address |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Interleaved output byte |

## Verification
The bench fills the SRAM with a non-zero pattern before the first frame. A design that read not-yet-written frames without masking them would then leak that pattern into the early frames, and this shows up against R7. It runs twenty frames, so the slot pointer wraps. A design with a wrong wrap or a wrong base address would read a source byte from the wrong region after frame 16. Stray input bytes and extra start pulses are sent during both phases; a design that honoured them would write unexpected addresses or shift later frames. Every output bit is compared against the permuted source bit. A reversed bit order within a byte, or a wrong delay table, shows up on the first frame that has real history.

// File: rtl/tint_pkg.sv
package tint_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;
endpackage

// File: rtl/tint_src_map.sv
// Maps a bit index to the slot of the frame that supplies it, and says
// whether that frame already exists.
module tint_src_map #(
    parameter int DEPTH = 16,
    localparam int LOG_D = $clog2(DEPTH)
) (
    input  logic [LOG_D-1:0] idx,
    input  logic [LOG_D-1:0] wptr,
    input  logic [LOG_D-1:0] fill,
    output logic [LOG_D-1:0] src_slot,
    output logic             src_live
);
    logic [LOG_D-1:0] delay;

    // Frame delay is the bit-reversed residue of the index.
    always_comb begin
        for (int j = 0; j < LOG_D; j++) begin
            delay[j] = idx[LOG_D-1-j];
        end
        src_slot = wptr - delay;
        src_live = (delay <= fill);
    end
endmodule

// File: rtl/tint_packer.sv
// Serial-to-byte packer; first bit lands in the MSB.
module tint_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_val,
    output logic       out_valid,
    output logic [7:0] out_data
);
    typedef struct packed {
        logic [6:0] sh;
        logic [2:0] cnt;
        logic       vld;
        logic [7:0] dat;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d     = pk_q;
        pk_d.vld = 1'b0;
        if (bit_vld) begin
            pk_d.sh  = {pk_q.sh[5:0], bit_val};
            pk_d.cnt = pk_q.cnt + 3'd1;
            if (pk_q.cnt == 3'd7) begin
                pk_d.dat = {pk_q.sh, bit_val};
                pk_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign out_valid = pk_q.vld;
    assign out_data  = pk_q.dat;

    // R9: a byte strobe is never followed by another on the next cycle
    p_out_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/tint_ctrl.sv
module tint_ctrl
    import tint_pkg::*;
#(
    parameter int FRAME_BYTES = 8192,
    parameter int DEPTH       = 16,
    localparam int LOG_D      = $clog2(DEPTH),
    localparam int OFS_W      = $clog2(FRAME_BYTES),
    localparam int BIT_W      = OFS_W + 3,
    localparam int ADDR_W     = LOG_D + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_wdata,
    output logic              sram_we,
    input  logic [7:0]        sram_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data
);
    localparam int FRAME_BITS = FRAME_BYTES * 8;

    typedef struct packed {
        phase_e            phase;
        logic [LOG_D-1:0]  wptr;
        logic [LOG_D-1:0]  fill;
        logic [BIT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              we;
        logic              rd_pend;
        logic              rd_zero;
        logic [2:0]        rd_sel;
        logic              pend2;
        logic              zero2;
        logic [2:0]        sel2;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [LOG_D-1:0] src_slot;
    logic             src_live;
    logic             bit_val;

    tint_src_map #(.DEPTH(DEPTH)) u_map (
        .idx      (c_q.cnt[LOG_D-1:0]),
        .wptr     (c_q.wptr),
        .fill     (c_q.fill),
        .src_slot (src_slot),
        .src_live (src_live)
    );

    always_comb begin
        c_d         = c_q;
        c_d.we      = 1'b0;
        c_d.rd_pend = 1'b0;
        c_d.pend2   = c_q.rd_pend;
        c_d.zero2   = c_q.rd_zero;
        c_d.sel2    = c_q.rd_sel;
        case (c_q.phase)
            PH_IDLE: begin
                if (frame_start) begin
                    c_d.phase = PH_WRITE;
                    c_d.cnt   = '0;
                end
            end
            PH_WRITE: begin
                if (in_valid) begin
                    c_d.we    = 1'b1;
                    c_d.addr  = {c_q.wptr, c_q.cnt[OFS_W-1:0]};
                    c_d.wdata = in_data;
                    if (c_q.cnt == BIT_W'(FRAME_BYTES - 1)) begin
                        c_d.phase = PH_READ;
                        c_d.cnt   = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            PH_READ: begin
                c_d.rd_pend = 1'b1;
                c_d.rd_zero = !src_live;
                c_d.rd_sel  = c_q.cnt[2:0];
                c_d.addr    = {src_slot, c_q.cnt[BIT_W-1:3]};
                if (c_q.cnt == BIT_W'(FRAME_BITS - 1)) begin
                    c_d.phase = PH_IDLE;
                    c_d.cnt   = '0;
                    c_d.wptr  = c_q.wptr + 1'b1;
                    if (c_q.fill != LOG_D'(DEPTH - 1)) c_d.fill = c_q.fill + 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign bit_val = c_q.zero2 ? 1'b0 : sram_rdata[3'd7 - c_q.sel2];

    tint_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (c_q.pend2),
        .bit_val   (bit_val),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign sram_addr  = c_q.addr;
    assign sram_wdata = c_q.wdata;
    assign sram_we    = c_q.we;

    // R2: a write strobe follows an accepted byte in the write phase
    p_we_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> $past(c_q.phase == PH_WRITE && in_valid));

    // R3: no SRAM write once the read phase has been entered
    p_read_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_READ) |=> !sram_we);

    // R8: the slot pointer only ever advances by one, modulo 16
    p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.wptr) |-> (c_q.wptr == LOG_D'($past(c_q.wptr) + 1'b1)));

    // R7: the history count moves only at a frame boundary
    p_fill_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.fill) |-> !$stable(c_q.wptr));
endmodule

// File: tb/sim_tint_ctrl.sv
module sim_tint_ctrl;
    localparam int FB     = 4;
    localparam int DEP    = 16;
    localparam int NFR    = 20;
    localparam int AW     = 6;
    localparam int NBITS  = FB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic [AW-1:0] sram_addr;
    logic [7:0]    sram_wdata;
    logic          sram_we;
    logic [7:0]    sram_rdata;
    logic          out_valid;
    logic [7:0]    out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int last_out = -100;
    int outs_in_frame = 0;

    logic [7:0] mem [DEP*FB];
    logic [7:0] hist [NFR][FB];
    int         exp_wa[$];
    logic [7:0] exp_wd[$];
    logic [7:0] exp_out[$];

    always #10 clk = ~clk;

    tint_ctrl #(.FRAME_BYTES(FB), .DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_valid(in_valid), .in_data(in_data),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
        .sram_rdata(sram_rdata), .out_valid(out_valid), .out_data(out_data)
    );

    // behavioural SRAM, one-cycle read latency
    initial begin
        for (int a = 0; a < DEP*FB; a++) mem[a] = 8'hA5;
        sram_rdata = 8'h00;
    end
    always @(posedge clk) begin
        if (sram_we) mem[sram_addr] <= sram_wdata;
        sram_rdata <= mem[sram_addr];
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_we) begin
                if (exp_wa.size() == 0) begin
                    check(1'b0, "R3 unexpected SRAM write", int'(sram_addr), -1);
                end else begin
                    int ea;
                    logic [7:0] ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    check(sram_addr == AW'(ea), "R2 R4 R8 write address", int'(sram_addr), ea);
                    check(sram_wdata == ed, "R2 write data", int'(sram_wdata), int'(ed));
                end
            end
            if (out_valid) begin
                check(cyc - last_out >= 8, "R9 output spacing", cyc - last_out, 8);
                last_out = cyc;
                outs_in_frame++;
                if (exp_out.size() == 0) begin
                    check(1'b0, "R5 unexpected output byte", int'(out_data), -1);
                end else begin
                    logic [7:0] eo;
                    eo = exp_out.pop_front();
                    check(out_data == eo, "R6 R7 output byte", int'(out_data), int'(eo));
                end
            end
        end
    end

    function automatic int brev4(input int k);
        int r = 0;
        for (int j = 0; j < 4; j++) if (((k >> j) & 1) != 0) r |= 1 << (3 - j);
        return r;
    endfunction

    task automatic build_expect(input int r);
        for (int ob = 0; ob < FB; ob++) begin
            logic [7:0] b = 8'h00;
            for (int m = 0; m < 8; m++) begin
                int i = ob * 8 + m;
                int src = r - brev4(i % 16);
                if (src >= 0) b[7-m] = hist[src][i/8][7-(i%8)];
            end
            exp_out.push_back(b);
        end
    endtask

    task automatic run_frame(input int r, input bit bubbles, input bit stray);
        int w;
        for (int k = 0; k < FB; k++) begin
            hist[r][k] = 8'((r * 73 + k * 29 + 17) ^ (r << 3));
            exp_wa.push_back((r % 16) * FB + k);
            exp_wd.push_back(hist[r][k]);
        end
        build_expect(r);
        outs_in_frame = 0;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int k = 0; k < FB; k++) begin
            if (bubbles) begin
                @(negedge clk);
            end
            frame_start = stray && (k == 1);
            in_valid = 1'b1;
            in_data  = hist[r][k];
            @(negedge clk);
            in_valid = 1'b0;
            frame_start = 1'b0;
        end
        // bytes offered during the read phase must be dropped (R3)
        if (stray) begin
            in_valid = 1'b1;
            for (int e = 0; e < 3; e++) begin
                in_data = 8'(8'hC3 + e);
                frame_start = (e == 1);
                @(negedge clk);
            end
            in_valid = 1'b0;
            frame_start = 1'b0;
        end
        w = 0;
        while (exp_out.size() != 0 && w < 2000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        check(outs_in_frame == FB, "R5 bytes per frame", outs_in_frame, FB);
        check(exp_wa.size() == 0, "R3 pending writes", exp_wa.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(sram_we == 1'b0, "R1 sram_we in reset", int'(sram_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // idle input must be ignored (R3)
        in_valid = 1'b1;
        for (int e = 0; e < 4; e++) begin
            in_data = 8'(8'h5A + e);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && exp_wa.size() == 0, "R1 R3 quiet after idle input",
              int'(out_valid), 0);
        for (int r = 0; r < NFR; r++) begin
            run_frame(r, (r % 3) == 1, (r % 4) == 2);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule